// File: doc/BRIEF.md
# ModRM/SIB Operand Address Decoder

This block works out how a memory or register operand is addressed in 32/64-bit mode. On a start strobe it takes the ModRM byte and the SIB byte, together with the two register-extension bits and a flag that says 16-bit addressing is in effect. It classifies the operand as one of four kinds: register direct, register indirect, base plus scaled index, or relative to the instruction pointer. It produces the base and index register numbers with their valid flags, the scale factor, and the number of displacement bytes the form needs.

When a displacement is needed, the block raises `in_ready` and takes that many bytes, lowest byte first, from a valid/ready byte stream. It sign-extends a one-byte displacement to 32 bits. When the last byte is taken, or right after the start strobe for forms that have no displacement, it pulses `done` for one cycle. All decoded outputs then hold their values until the next accepted start. The caller reads the result on the `done` cycle or at any later point before it issues the next start.

Top module: `modrm_addr_decode`

## Requirements
- R1: A SIB form (kind code 2) is chosen only when mod (bits 7:6 of `modrm`) is not 11, rm (bits 2:0) equals 100, and `flat16` is low. With `flat16` high, rm=100 is decoded as an ordinary register code.
- R2: In a SIB form, `scale` equals 1 shifted left by SIB bits 7:6, so it is one of 1, 2, 4 or 8.
- R3: In a SIB form, `idx_reg` is {`rex_x`, SIB bits 5:3}, and `idx_vld` is low only when that 4-bit code is 0100.
- R4: In a SIB form, `base_reg` is {`rex_b`, SIB bits 2:0}. The exception is mod=00 with SIB bits 2:0 equal to 101: then `base_vld` is low (for either value of `rex_b`) and 4 displacement bytes are taken.
- R5: Without SIB, mod=00 and rm=101 give kind code 3 (instruction-pointer relative). This form has no valid base or index and takes 4 displacement bytes.
- R6: Without SIB, mod=00 with any other rm gives kind code 1 (register indirect). The base is {`rex_b`, rm}, there is no index, the scale is 1, and the displacement is 0.
- R7: mod=01 takes one byte, sign-extended to 32 bits. mod=10 takes four bytes, assembled with the first byte as the least significant.
- R8: mod=11 gives kind code 0 (register direct) with base {`rex_b`, rm}. No byte is taken, and `in_ready` stays low.
- R9: `done` is high for exactly the one cycle that follows the edge at which the last displacement byte is accepted. For a form with no displacement, it is the cycle that follows the start edge. `nbytes` reports 0, 1 or 4.
- R10: The decoded outputs hold until the next accepted start. A start raised while `busy` is high is ignored, and so are stream bytes offered while `busy` is low.
- R11: A synchronous `rst` clears `busy`, `done` and `in_ready`, and this abandons any decode in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin decoding the operand bytes presented this cycle |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte, used only for SIB forms |
| rex_b | input | 1 | Extension bit for the base or rm register |
| rex_x | input | 1 | Extension bit for the index register |
| flat16 | input | 1 | 16-bit addressing in effect; suppresses SIB |
| in_valid | input | 1 | Displacement byte available |
| in_data | input | 8 | Displacement byte |
| in_ready | output | 1 | Block accepts a displacement byte |
| busy | output | 1 | Displacement collection in progress |
| done | output | 1 | One-cycle completion pulse |
| kind | output | 2 | 0 direct, 1 indirect, 2 SIB, 3 IP-relative |
| base_reg | output | 4 | Base register number |
| base_vld | output | 1 | Base register present |
| idx_reg | output | 4 | Index register number |
| idx_vld | output | 1 | Index register present |
| scale | output | 4 | Index scale 1, 2, 4 or 8 |
| disp | output | 32 | Sign-extended displacement |
| nbytes | output | 3 | Displacement bytes consumed |

## Verification
Two functions can fall in the same cycle: a new start strobe and the acceptance of a displacement byte for the operation already in flight. The bench provokes this by raising `start`, with a scrambled ModRM byte, on the very cycle the first byte is handed over. It then judges the outcome by comparing the finished result with the model's result for the original bytes. A second overlap is the `done` cycle meeting stray stream traffic. The bench drives `in_valid` with junk data right after completion and checks that neither the outputs nor `done` move.

// File: rtl/modrm_addr_decode.sv
module modrm_addr_decode (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  modrm,
  input  logic [7:0]  sib,
  input  logic        rex_b,
  input  logic        rex_x,
  input  logic        flat16,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        busy,
  output logic        done,
  output logic [1:0]  kind,
  output logic [3:0]  base_reg,
  output logic        base_vld,
  output logic [3:0]  idx_reg,
  output logic        idx_vld,
  output logic [3:0]  scale,
  output logic [31:0] disp,
  output logic [2:0]  nbytes
);

  localparam logic [1:0] K_DIR = 2'd0;
  localparam logic [1:0] K_IND = 2'd1;
  localparam logic [1:0] K_SIB = 2'd2;
  localparam logic [1:0] K_RIP = 2'd3;

  logic [1:0] md;
  logic [2:0] rm;
  logic       use_sib;
  assign md      = modrm[7:6];
  assign rm      = modrm[2:0];
  assign use_sib = (md != 2'b11) && (rm == 3'b100) && !flat16;

  logic [1:0] d_kind;
  logic [3:0] d_base, d_idx, d_scale;
  logic       d_bv, d_iv;
  logic [2:0] d_need;

  always_comb begin
    d_kind  = K_IND;
    d_base  = {rex_b, rm};
    d_bv    = 1'b1;
    d_idx   = 4'd0;
    d_iv    = 1'b0;
    d_scale = 4'd1;
    d_need  = (md == 2'b01) ? 3'd1 : (md == 2'b10) ? 3'd4 : 3'd0;
    if (md == 2'b11) begin
      d_kind = K_DIR;
    end else if (use_sib) begin
      d_kind  = K_SIB;
      d_scale = 4'd1 << sib[7:6];
      d_idx   = {rex_x, sib[5:3]};
      d_iv    = ({rex_x, sib[5:3]} != 4'b0100);
      d_base  = {rex_b, sib[2:0]};
      if (md == 2'b00 && sib[2:0] == 3'b101) begin
        d_bv   = 1'b0;
        d_base = 4'd0;
        d_need = 3'd4;
      end
    end else if (md == 2'b00 && rm == 3'b101) begin
      d_kind = K_RIP;
      d_bv   = 1'b0;
      d_base = 4'd0;
      d_need = 3'd4;
    end
  end

  logic [2:0]  cnt;
  logic [31:0] raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= 3'd0;
      raw      <= 32'd0;
      kind     <= K_DIR;
      base_reg <= 4'd0;
      base_vld <= 1'b0;
      idx_reg  <= 4'd0;
      idx_vld  <= 1'b0;
      scale    <= 4'd1;
      nbytes   <= 3'd0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        kind     <= d_kind;
        base_reg <= d_base;
        base_vld <= d_bv;
        idx_reg  <= d_idx;
        idx_vld  <= d_iv;
        scale    <= d_scale;
        nbytes   <= d_need;
        raw      <= 32'd0;
        cnt      <= 3'd0;
        if (d_need == 3'd0) done <= 1'b1;
        else                busy <= 1'b1;
      end else if (busy && in_valid) begin
        raw[{cnt[1:0], 3'b000} +: 8] <= in_data;
        cnt <= cnt + 3'd1;
        if ((cnt + 3'd1) == nbytes) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign in_ready = busy;
  assign disp     = (nbytes == 3'd1) ? {{24{raw[7]}}, raw[7:0]} : raw;

endmodule

// File: rtl/modrm_addr_decode_chk.sv
module modrm_addr_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        in_ready,
  input logic        busy,
  input logic        done,
  input logic [1:0]  kind,
  input logic [3:0]  base_reg,
  input logic        base_vld,
  input logic        idx_vld,
  input logic [3:0]  scale,
  input logic [31:0] disp,
  input logic [2:0]  nbytes
);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  p_direct_shape_r8: assert property (@(posedge clk) disable iff (rst)
    (done && kind == 2'd0) |-> (nbytes == 3'd0 && base_vld && !idx_vld));

  p_rip_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (done && kind == 2'd3) |-> (nbytes == 3'd4 && !base_vld && !idx_vld));

  p_scale_pow2_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(scale) == 1 && scale <= 4'd8));

  p_sext_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (done && nbytes == 3'd1) |-> (disp[31:8] == {24{disp[7]}}));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |->
      ($stable(disp) && $stable(kind) && $stable(base_reg) && $stable(nbytes)));

  p_reset_idle_r11: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !in_ready));

endmodule

bind modrm_addr_decode modrm_addr_decode_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready), .busy(busy),
  .done(done), .kind(kind), .base_reg(base_reg), .base_vld(base_vld),
  .idx_vld(idx_vld), .scale(scale), .disp(disp), .nbytes(nbytes)
);

// File: tb/test_modrm_addr_decode.sv
module test_modrm_addr_decode;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] modrm = 8'd0, sib = 8'd0, in_data = 8'd0;
  logic rex_b = 1'b0, rex_x = 1'b0, flat16 = 1'b0, in_valid = 1'b0;
  logic in_ready, busy, done, base_vld, idx_vld;
  logic [1:0] kind;
  logic [3:0] base_reg, idx_reg, scale;
  logic [31:0] disp;
  logic [2:0] nbytes;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_addr_decode i_modrm_addr_decode (
    .clk(clk), .rst(rst), .start(start), .modrm(modrm), .sib(sib),
    .rex_b(rex_b), .rex_x(rex_x), .flat16(flat16), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done),
    .kind(kind), .base_reg(base_reg), .base_vld(base_vld), .idx_reg(idx_reg),
    .idx_vld(idx_vld), .scale(scale), .disp(disp), .nbytes(nbytes)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind, base, base_vld, idx, idx_vld, scale, need}
  function automatic logic [18:0] model(input logic [7:0] m, input logic [7:0] s,
                                        input logic rb, input logic rx, input logic f);
    logic [1:0] k; logic [3:0] br, ir, sc; logic bv, iv; logic [2:0] n;
    k = 2'd1; br = 4'd0; ir = 4'd0; sc = 4'd1; bv = 1'b0; iv = 1'b0; n = 3'd0;
    case (m[7:6])
      2'b11: begin k = 2'd0; br = {rb, m[2:0]}; bv = 1'b1; end
      default: begin
        case (m[7:6]) 2'b01: n = 3'd1; 2'b10: n = 3'd4; default: n = 3'd0; endcase
        if (m[2:0] == 3'd4 && !f) begin
          k = 2'd2;
          case (s[7:6]) 2'd0: sc = 4'd1; 2'd1: sc = 4'd2; 2'd2: sc = 4'd4; default: sc = 4'd8; endcase
          ir = {rx, s[5:3]};
          iv = !(rx == 1'b0 && s[5:3] == 3'd4);
          if (m[7:6] == 2'b00 && s[2:0] == 3'd5) begin bv = 1'b0; n = 3'd4; end
          else begin bv = 1'b1; br = {rb, s[2:0]}; end
        end else if (m[7:6] == 2'b00 && m[2:0] == 3'd5) begin
          k = 2'd3; n = 3'd4;
        end else begin
          k = 2'd1; bv = 1'b1; br = {rb, m[2:0]};
        end
      end
    endcase
    return {k, br, bv, ir, iv, sc, n};
  endfunction

  task automatic run_op(input logic [7:0] m, input logic [7:0] s, input logic rb,
                        input logic rx, input logic f, input int gap_pct, input bit poke);
    logic [18:0] e;
    logic [7:0] b [4];
    logic [31:0] edisp;
    logic [2:0] need;
    int got;
    bit v;
    e = model(m, s, rb, rx, f);
    need = e[2:0];
    for (int i = 0; i < 4; i++) b[i] = 8'($urandom);
    edisp = (need == 3'd1) ? {{24{b[0][7]}}, b[0]} :
            (need == 3'd4) ? {b[3], b[2], b[1], b[0]} : 32'd0;
    @(negedge clk);
    modrm = m; sib = s; rex_b = rb; rex_x = rx; flat16 = f; start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0; modrm = 8'($urandom); sib = 8'($urandom); rex_b = 1'($urandom); rex_x = 1'($urandom);
    got = 0;
    if (need == 3'd0) chk(in_ready == 1'b0, "R8 no stream request", 32'(in_ready), 32'd0);
    while (got < int'(need)) begin
      chk(done == 1'b0, "R9 early done", 32'(done), 32'd0);
      chk(in_ready == 1'b1, "R7 ready while collecting", 32'(in_ready), 32'd1);
      v = ($urandom % 100) >= gap_pct;
      in_valid = v;
      in_data = v ? b[got] : 8'($urandom);
      if (poke && got == 0) begin start = 1'b1; modrm = 8'($urandom); end
      @(negedge clk);
      start = 1'b0;
      if (v) got++;
    end
    in_valid = 1'b0;
    chk(done == 1'b1, "R9 done timing", 32'(done), 32'd1);
    chk(kind == e[18:17], "R1 kind", 32'(kind), 32'(e[18:17]));
    chk(base_vld == e[12], "R4 base valid", 32'(base_vld), 32'(e[12]));
    if (e[12]) chk(base_reg == e[16:13], "R6 base reg", 32'(base_reg), 32'(e[16:13]));
    chk(idx_vld == e[7], "R3 index valid", 32'(idx_vld), 32'(e[7]));
    if (e[7]) chk(idx_reg == e[11:8], "R3 index reg", 32'(idx_reg), 32'(e[11:8]));
    chk(scale == e[6:3], "R2 scale", 32'(scale), 32'(e[6:3]));
    chk(nbytes == need, "R9 byte count", 32'(nbytes), 32'(need));
    chk(disp == edisp, "R7 displacement", disp, edisp);
    in_valid = 1'b1; in_data = 8'($urandom);
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b0, "R9 single pulse", 32'(done), 32'd0);
    chk(disp == edisp && kind == e[18:17], "R10 hold", disp, edisp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R11 reset state",
        {29'd0, busy, done, in_ready}, 32'd0);
    rst = 1'b0;
    run_op(8'b11_000_100, 8'h00, 1'b1, 1'b0, 1'b0, 0, 1'b0);  // R8 rm=100 direct
    run_op(8'b01_000_100, 8'h00, 1'b0, 1'b0, 1'b1, 0, 1'b0);  // R1 flat16
    run_op(8'b00_000_101, 8'h00, 1'b1, 1'b1, 1'b0, 30, 1'b0); // R5
    run_op(8'b00_000_011, 8'h00, 1'b1, 1'b0, 1'b0, 0, 1'b0);  // R6
    run_op(8'b00_000_100, 8'b11_100_101, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R4 no base, R3 no index
    run_op(8'b01_000_100, 8'b10_100_101, 1'b0, 1'b1, 1'b0, 0, 1'b0); // R3 extended index
    run_op(8'b10_000_100, 8'b01_010_011, 1'b1, 1'b1, 1'b0, 50, 1'b0);
    run_op(8'b01_000_001, 8'h00, 1'b0, 1'b0, 1'b0, 0, 1'b1);  // R10 start while busy
    run_op(8'b10_000_110, 8'h00, 1'b0, 1'b0, 1'b0, 20, 1'b1);
    for (int i = 0; i < 300; i++) begin
      m = 8'($urandom);
      if ($urandom % 100 < 40) m[2:0] = 3'b100;
      run_op(m, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 100) < 10, 25, ($urandom % 8) == 0);
    end
    // R11: reset in the middle of a collection
    @(negedge clk);
    modrm = 8'b10_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b1; in_data = 8'h5a;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0 && in_ready == 1'b0 && done == 1'b0, "R11 abort",
        {29'd0, busy, in_ready, done}, 32'd0);
    run_op(8'b01_011_010, 8'h00, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule